// File: doc/BRIEF.md
# Exponential Backoff Stall Generator

This block tells a requester how long to wait before it retries a compare-and-swap that failed. It keeps one backoff value, which is a power of two. The value is 1 after reset and after every successful operation. Each accepted failure reports a stall request built from the current value. The value then doubles for the next failure, unless it is already above a ceiling of 4096. In that case it stays where it is, so the largest value is 8192.

The stall request takes one of two forms, chosen by a mode input that is sampled on the failure. In pause mode, one request carries a cycle count equal to the backoff value shifted left by 7. That count goes to an external pause unit, and the block is busy only for the cycle of the request. In spin mode, the request carries a count of spin iterations equal to the backoff value plus one. The block then stays busy while it times those iterations itself, at a fixed number of cycles per iteration (128 by default). A failure that arrives while the block is busy is dropped.

Top module: `backoff_stall_gen`

## Requirements
- R1: After reset, `stall_req_o` and `busy_o` are 0, and the first accepted failure uses a backoff value of 1.
- R2: A failure is accepted when `fail_i`=1, `success_i`=0 and `busy_o`=0 at a clock edge. `stall_req_o` is then 1 for exactly the one following cycle, with `stall_amt_o` valid in that cycle.
- R3: After each accepted failure the backoff value doubles, provided it was at most 4096 (1, 2, 4, ..., 4096, 8192).
- R4: Once the backoff value exceeds 4096 (that is, 8192), later accepted failures leave it unchanged.
- R5: When `pause_mode_i`=1 on an accepted failure, `stall_amt_o` equals the backoff value shifted left by 7, and `busy_o` is 1 only in the request cycle.
- R6: When `pause_mode_i`=0 on an accepted failure, `stall_amt_o` equals the backoff value plus 1. `busy_o` is then 1 for exactly (backoff+1)*SPIN_CYCLES consecutive cycles, starting with the request cycle.
- R7: A failure that arrives while `busy_o`=1 is ignored. It raises no request, does not change the backoff value and does not lengthen the stall.
- R8: `success_i`=1 at an edge resets the backoff value to 1, whether or not the block is busy. A failure in the same cycle as a success is not accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fail_i | input | 1 | Pulse: the compare-and-swap failed |
| success_i | input | 1 | Pulse: the compare-and-swap succeeded |
| pause_mode_i | input | 1 | 1 = single scaled pause request, 0 = timed spin iterations |
| stall_req_o | output | 1 | Stall request valid, one cycle |
| stall_amt_o | output | AMT_W (21) | Pause cycles (pause mode) or spin iterations (spin mode) |
| busy_o | output | 1 | A stall is in progress; failures are dropped |

## Verification
A wrong backoff value appears on `stall_amt_o` at the very next accepted failure, whether it is a doubling missed, a saturation taken early or a success that did not clear. In spin mode it also shows as a wrong `busy_o` length one request later. A fault in the spin timer is visible within one stall as a `busy_o` window whose cycle count differs from (backoff+1) times the iteration length. A fault in the busy gate shows as a second request or a doubled backoff on the next request after a failure injected mid-stall. The bench walks the value through saturation, mixes modes and successes at random, and injects failures during stalls.

// File: rtl/backoff_pkg.sv
package backoff_pkg;

  // Next backoff value: double unless already above the ceiling.
  function automatic int unsigned next_backoff(input int unsigned cur,
                                               input int unsigned ceil_v);
    return (cur > ceil_v) ? cur : (cur << 1);
  endfunction

  // Pause-mode cycle count.
  function automatic int unsigned pause_cycles(input int unsigned cur,
                                               input int unsigned shift_v);
    return cur << shift_v;
  endfunction

  // Spin-mode iteration count: the zero test precedes the decrement.
  function automatic int unsigned spin_iters(input int unsigned cur);
    return cur + 1;
  endfunction

endpackage

// File: rtl/backoff_value_reg.sv
module backoff_value_reg #(
  parameter int unsigned CEILING = 4096,
  localparam int unsigned BO_W = $clog2(CEILING) + 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            advance_i,
  input  logic            clear_i,
  output logic [BO_W-1:0] value_o
);
  logic [BO_W-1:0] value_q;
  logic [BO_W-1:0] value_next;

  assign value_next = BO_W'(backoff_pkg::next_backoff(32'(value_q), CEILING));

  always_ff @(posedge clk) begin
    if (!rst_n)          value_q <= BO_W'(1);
    else if (clear_i)    value_q <= BO_W'(1);
    else if (advance_i)  value_q <= value_next;
  end

  assign value_o = value_q;

  // R3/R4: the value is always a single power of two
  a_r3_power_of_two: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(value_q) == 1);
  // R3: below or at the ceiling an advance doubles
  a_r3_doubles: assert property (@(posedge clk) disable iff (!rst_n)
    (advance_i && !clear_i && 32'(value_q) <= CEILING) |=> (32'(value_q) == 2 * 32'($past(value_q))));
  // R4: above the ceiling an advance holds
  a_r4_saturates: assert property (@(posedge clk) disable iff (!rst_n)
    (advance_i && !clear_i && 32'(value_q) > CEILING) |=> $stable(value_q));
  // R8: clear returns to one
  a_r8_clear_to_one: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (value_q == BO_W'(1)));
endmodule

// File: rtl/backoff_spin_timer.sv
module backoff_spin_timer #(
  parameter int unsigned ITER_W      = 14,
  parameter int unsigned SPIN_CYCLES = 128,
  localparam int unsigned CYC_W = $clog2(SPIN_CYCLES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ITER_W-1:0] iters_left_i,
  output logic              busy_o,
  output logic              done_o
);
  logic              busy_q;
  logic [ITER_W-1:0] iter_q;
  logic [CYC_W-1:0]  cyc_q;
  logic              iter_end;

  assign iter_end = (cyc_q == '0);
  assign done_o   = busy_q && iter_end && (iter_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      iter_q <= '0;
      cyc_q  <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      iter_q <= iters_left_i;
      cyc_q  <= CYC_W'(SPIN_CYCLES - 1);
    end else if (busy_q) begin
      if (done_o) begin
        busy_q <= 1'b0;
      end else if (iter_end) begin
        iter_q <= iter_q - ITER_W'(1);
        cyc_q  <= CYC_W'(SPIN_CYCLES - 1);
      end else begin
        cyc_q <= cyc_q - CYC_W'(1);
      end
    end
  end

  assign busy_o = busy_q;

  // R7: a stall is never restarted while one runs
  a_r7_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |-> !busy_q);
  // R6: busy only drops through completion
  a_r6_drop_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !done_o) |=> busy_q);
  a_r6_done_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start_i) |=> !busy_q);
endmodule

// File: rtl/backoff_stall_gen.sv
module backoff_stall_gen #(
  parameter int unsigned CEILING     = 4096,
  parameter int unsigned SCALE_SHIFT = 7,
  parameter int unsigned SPIN_CYCLES = 128,
  localparam int unsigned BO_W  = $clog2(CEILING) + 2,
  localparam int unsigned AMT_W = BO_W + SCALE_SHIFT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fail_i,
  input  logic             success_i,
  input  logic             pause_mode_i,
  output logic             stall_req_o,
  output logic [AMT_W-1:0] stall_amt_o,
  output logic             busy_o
);
  logic [BO_W-1:0]  backoff;
  logic             accept;
  logic             spin_start;
  logic             spin_busy;
  logic             spin_done;
  logic             pause_q;
  logic             req_q;
  logic [AMT_W-1:0] amt_q;
  logic [AMT_W-1:0] amt_next;

  assign accept     = fail_i && !success_i && !busy_o;
  assign spin_start = accept && !pause_mode_i;

  backoff_value_reg #(.CEILING(CEILING)) u_value (
    .clk       (clk),
    .rst_n     (rst_n),
    .advance_i (accept),
    .clear_i   (success_i),
    .value_o   (backoff)
  );

  backoff_spin_timer #(.ITER_W(BO_W), .SPIN_CYCLES(SPIN_CYCLES)) u_timer (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (spin_start),
    .iters_left_i (backoff),
    .busy_o       (spin_busy),
    .done_o       (spin_done)
  );

  assign amt_next = pause_mode_i
      ? AMT_W'(backoff_pkg::pause_cycles(32'(backoff), SCALE_SHIFT))
      : AMT_W'(backoff_pkg::spin_iters(32'(backoff)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q   <= 1'b0;
      pause_q <= 1'b0;
      amt_q   <= '0;
    end else begin
      req_q   <= accept;
      pause_q <= accept && pause_mode_i;
      if (accept) amt_q <= amt_next;
    end
  end

  assign stall_req_o = req_q;
  assign stall_amt_o = amt_q;
  assign busy_o      = spin_busy || pause_q;

  // R2: a request lasts one cycle
  a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    stall_req_o |=> !stall_req_o);
  // R2: a request always comes with busy
  a_r2_req_busy: assert property (@(posedge clk) disable iff (!rst_n)
    stall_req_o |-> busy_o);
  // R7: no request follows a failure seen while busy
  a_r7_drop_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> !stall_req_o);
  // R8: success suppresses the request
  a_r8_success_wins: assert property (@(posedge clk) disable iff (!rst_n)
    success_i |=> !stall_req_o);
  // R5: pause amount is a scaled power of two
  a_r5_pause_shape: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_req_o && pause_q) |-> ($countones(stall_amt_o) == 1 &&
                                  stall_amt_o[SCALE_SHIFT-1:0] == '0));
  // R5: pause mode holds busy for the request cycle only
  a_r5_pause_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (pause_q && !spin_busy) |=> !busy_o);
  // R6: the spin timer completes before busy can fall
  a_r6_spin_done: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(spin_busy)) |-> $past(spin_done));
endmodule

// File: tb/backoff_stall_gen_tb.sv
module backoff_stall_gen_tb_top;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned SPIN = 4;
  localparam int unsigned CEIL = 4096;
  localparam int unsigned AMT_W = 21;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fail_i = 1'b0;
  logic success_i = 1'b0;
  logic pause_mode_i = 1'b0;
  logic stall_req_o;
  logic [AMT_W-1:0] stall_amt_o;
  logic busy_o;

  int unsigned checks = 0;
  int unsigned errors = 0;
  int unsigned model_bo = 1;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  backoff_stall_gen #(.SPIN_CYCLES(SPIN)) dut_i (
    .clk(clk), .rst_n(rst_n), .fail_i(fail_i), .success_i(success_i),
    .pause_mode_i(pause_mode_i), .stall_req_o(stall_req_o),
    .stall_amt_o(stall_amt_o), .busy_o(busy_o)
  );

  function automatic int unsigned exp_next(int unsigned b);
    if (b > CEIL) return b;
    return b * 2;
  endfunction

  function automatic int unsigned exp_amt(int unsigned b, bit pm);
    return pm ? b * 128 : b + 1;
  endfunction

  task automatic check(string req, int unsigned act, int unsigned exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Drive one failure; optionally inject a failure mid-stall (R7).
  task automatic do_fail(bit pm, bit inject);
    int unsigned n;
    @(negedge clk);
    fail_i = 1'b1; pause_mode_i = pm;
    @(negedge clk);
    fail_i = 1'b0; pause_mode_i = ~pm;
    check("R2 req", 32'(stall_req_o), 1);
    check(pm ? "R5 amount" : "R6 amount", 32'(stall_amt_o), exp_amt(model_bo, pm));
    n = 0;
    while (busy_o && n < 200000) begin
      n++;
      if (inject && n == 2) fail_i = 1'b1;
      @(negedge clk);
      fail_i = 1'b0;
      if (n >= 1 && busy_o) check("R7 no req while busy", 32'(stall_req_o), 0);
    end
    check(pm ? "R5 busy length" : "R6 busy length", n,
          pm ? 1 : (model_bo + 1) * SPIN);
    model_bo = exp_next(model_bo);
  endtask

  task automatic do_success(bit with_fail);
    @(negedge clk);
    success_i = 1'b1; fail_i = with_fail;
    @(negedge clk);
    success_i = 1'b0; fail_i = 1'b0;
    check("R8 no req on success", 32'(stall_req_o), 0);
    model_bo = 1;
  endtask

  initial begin
    #(CLK_PERIOD * 250000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R1 req after reset", 32'(stall_req_o), 0);
    check("R1 busy after reset", 32'(busy_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle", 32'(busy_o), 0);
    // R1/R6: first request in spin mode uses backoff 1
    do_fail(1'b0, 1'b0);
    do_fail(1'b0, 1'b1); // R7 injection
    do_fail(1'b0, 1'b0); // R3: must show 4 (+1)
    // R3/R4: climb through the ceiling in pause mode
    for (int i = 0; i < 16; i++) do_fail(1'b1, 1'b0);
    check("R4 saturated", model_bo, 8192);
    do_fail(1'b1, 1'b1);
    // R8 success resets, with and without a simultaneous failure
    do_success(1'b1);
    do_fail(1'b1, 1'b0);
    do_success(1'b0);
    do_fail(1'b0, 1'b0);
    // R8: success during a spin stall resets for the next sequence
    @(negedge clk); fail_i = 1'b1; pause_mode_i = 1'b0;
    @(negedge clk); fail_i = 1'b0;
    @(negedge clk); success_i = 1'b1;
    @(negedge clk); success_i = 1'b0;
    while (busy_o) @(negedge clk);
    model_bo = 1;
    do_fail(1'b1, 1'b0);
    // Random mix
    for (int i = 0; i < 60; i++) begin
      int unsigned r;
      r = $urandom_range(0, 9);
      if (r == 0) do_success($urandom_range(0, 1) == 1);
      else if (model_bo <= 512 && r < 5) do_fail(1'b0, $urandom_range(0, 1) == 1);
      else do_fail(1'b1, $urandom_range(0, 1) == 1);
      repeat ($urandom_range(0, 3)) @(negedge clk);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule